// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

A memory-mapped timer peripheral with a parameterised number of independent 64-bit down-counters, two by default. Each channel has a control word, a 64-bit interval and a readable 64-bit current count. The interval and the count are each reached as a low and a high 32-bit word. Software arms a channel by writing its control word with the enable and reload bits set. That write copies the interval into the counter, and the counter then steps down once per prescaled tick.

On expiry the channel raises its bit in a shared status register. In periodic mode the channel reloads the interval and keeps running. In one-shot mode it stops at zero and clears its own enable. A shared enable register masks which status bits drive the single interrupt line. Status bits are cleared by writing ones.

Clearing the enable bit stops the counter within two clock cycles, so the count stays put and can be read back. Setting enable again without reload resumes counting from the held value. Reading the count's low word captures the high word in the same cycle, which gives software a coherent 64-bit snapshot.

Top module: `evt_tmr`

## Requirements
- R1: After reset every register reads 0, all channels are stopped and `irq` is low.
- R2: Control word fields: bit 0 is enable, bit 1 is reload, bits 6:4 are the prescale select and bit 7 selects one-shot mode (1) or periodic mode (0). Reload always reads back as 0 and bits 3:2 read as 0.
- R3: A control write with reload set loads the interval into the counter at that clock edge. With select s, the count `k` cycles later is `interval - floor(k / 2^s)` until expiry.
- R4: The prescaler gives one count step every 2^s clock cycles for every select s from 0 to 7.
- R5: In periodic mode, a tick that finds the count at 1 or 0 reloads the interval and keeps the channel enabled. With an interval I ≥ 1, the count `k` ticks after start is `I - (k mod I)`.
- R6: In one-shot mode, the expiring tick sets the count to 0 and clears the enable bit. The count then stays at 0.
- R7: An expiry sets the channel's bit n in the status register (offset 0x04). Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as the clear wins.
- R8: `irq` is high exactly when some channel has both its status bit and its enable bit (offset 0x00, bit n) set.
- R9: After enable is cleared, the count changes on at most the next two clock edges and then holds.
- R10: A read of count-low captures that channel's count-high in the same cycle. A following read of count-high returns the captured word, so the two halves form the count at the time of the low read.
- R11: Register map, byte addresses: 0x00 interrupt enable, 0x04 status. Channel n has its control word at 0x20n+0x10, interval low at +0x14, interval high at +0x18, count low at +0x1C and count high at 0x20n+0x20. Unmapped addresses read 0 and ignore writes.
- R12: Setting enable without reload resumes counting from the held count. The first step comes two cycles after the write, so the count `k ≥ 1` cycles after the write is `held - (k - 1)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counters |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; used to capture count-high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt: OR over channels of status AND enable |

## Verification
Assertions inside the channel and top modules check every cycle that:
- a reload write lands the interval in the counter;
- each non-final tick lowers the count by exactly one;
- an expiry reloads in periodic mode and halts at zero in one-shot mode;
- a stopped channel with its sync stage drained holds its count;
- a status bit is set by expiry and otherwise changes only through a write of one.

Only the bench scenarios can show the properties that depend on the register map and on bus sequences. These are the prescale ratio for every select value, the address map, the masking of `irq` by the enable register, the two-cycle stop window seen from the bus, resuming from a held count, and the coherent pairing of a count-low read with a later count-high read.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    typedef struct packed {
        logic       oneshot;
        logic [2:0] psel;
        logic [1:0] spare;
        logic       reload;
        logic       run_en;
    } ctl_t;

    localparam logic [7:0] A_IEN     = 8'h00;
    localparam logic [7:0] A_IST     = 8'h04;
    localparam logic [7:0] A_CH_BASE = 8'h10;

    localparam logic [4:0] O_CTL    = 5'h00;
    localparam logic [4:0] O_IVL_LO = 5'h04;
    localparam logic [4:0] O_IVL_HI = 5'h08;
    localparam logic [4:0] O_CNT_LO = 5'h0C;
    localparam logic [4:0] O_CNT_HI = 5'h10;

    function automatic ctl_t ctl_sanitize(input logic [7:0] raw);
        ctl_t c;
        c = ctl_t'(raw);
        c.reload = 1'b0;
        c.spare  = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/evt_tmr_prescale.sv
module evt_tmr_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    assign lim  = DIV_W'((32'd1 << sel) - 32'd1);
    assign tick = run && (div_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            div_q <= '0;
        else if (run)
            div_q <= tick ? '0 : div_q + 1'b1;
    end

    p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && !tick) |=> (div_q == $past(div_q) + 1'b1));

endmodule

// File: rtl/evt_tmr_channel.sv
module evt_tmr_channel
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    input  logic [CNT_W-1:0] interval,
    output ctl_t             ctl_rd,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    ctl_t             ctl_q;
    ctl_t             ctl_new;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             load;
    logic             last;

    assign ctl_new = ctl_t'(ctl_wdata);
    assign load    = ctl_wr && ctl_new.reload;
    assign last    = (cnt_q[CNT_W-1:1] == '0);
    assign expire  = tick && !ctl_wr && last;
    assign ctl_rd  = ctl_q;
    assign count   = cnt_q;

    evt_tmr_prescale #(.SEL_W(3)) u_pre (
        .clk (clk),
        .rst (rst),
        .clr (load),
        .run (run_q),
        .sel (ctl_q.psel),
        .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= ctl_q.run_en;
            if (ctl_wr) begin
                ctl_q <= ctl_sanitize(ctl_wdata);
                if (load) begin
                    cnt_q <= interval;
                    run_q <= ctl_new.run_en;
                end
            end else if (tick) begin
                if (last) begin
                    if (ctl_q.oneshot) begin
                        cnt_q        <= '0;
                        ctl_q.run_en <= 1'b0;
                        run_q        <= 1'b0;
                    end else begin
                        cnt_q <= interval;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(interval)));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctl_wr && !last) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctl_q.oneshot) |=> (ctl_q.run_en && cnt_q == $past(interval)));

    p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && ctl_q.oneshot) |=> (!ctl_q.run_en && cnt_q == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.run_en && !run_q && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
    import evt_tmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    localparam int DATA_W = 32;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int CI_W   = ADDR_W - 5;

    logic [NCH-1:0]    ien_q;
    logic [NCH-1:0]    ist_q;
    logic [NCH-1:0]    expire;
    logic [CNT_W-1:0]  ivl_q  [NCH];
    logic [CNT_W-1:0]  cnt_w  [NCH];
    ctl_t              ctl_rd [NCH];
    logic [DATA_W-1:0] hi_snap_q;

    logic [ADDR_W-1:0] rel;
    logic [CI_W-1:0]   ch_idx;
    logic [4:0]        off;
    logic              in_ch;
    logic              ist_wr;

    assign rel    = addr - ADDR_W'(A_CH_BASE);
    assign ch_idx = rel[ADDR_W-1:5];
    assign off    = rel[4:0];
    assign in_ch  = (addr >= ADDR_W'(A_CH_BASE)) && (32'(ch_idx) < NCH);
    assign ist_wr = wr_en && (addr == ADDR_W'(A_IST));
    assign irq    = |(ist_q & ien_q);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = in_ch && (ch_idx == CI_W'(g));

        evt_tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .ctl_wr   (wr_en && hit && off == O_CTL),
            .ctl_wdata(wdata[7:0]),
            .interval (ivl_q[g]),
            .ctl_rd   (ctl_rd[g]),
            .count    (cnt_w[g]),
            .expire   (expire[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                ivl_q[g] <= '0;
                ist_q[g] <= 1'b0;
            end else begin
                if (wr_en && hit && off == O_IVL_LO) ivl_q[g][DATA_W-1:0]     <= wdata;
                if (wr_en && hit && off == O_IVL_HI) ivl_q[g][CNT_W-1:DATA_W] <= wdata;
                ist_q[g] <= expire[g] | (ist_q[g] & ~(ist_wr & wdata[g]));
            end
        end

        p_status_set_r7: assert property (@(posedge clk) disable iff (rst)
            expire[g] |=> ist_q[g]);

        p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (!expire[g] && !(ist_wr && wdata[g])) |=> (ist_q[g] == $past(ist_q[g])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q     <= '0;
            hi_snap_q <= '0;
        end else begin
            if (wr_en && addr == ADDR_W'(A_IEN)) ien_q <= wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++)
                if (rd_en && in_ch && ch_idx == CI_W'(i) && off == O_CNT_LO)
                    hi_snap_q <= cnt_w[i][CNT_W-1:DATA_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_IEN)) rdata = DATA_W'(ien_q);
        if (addr == ADDR_W'(A_IST)) rdata = DATA_W'(ist_q);
        for (int i = 0; i < NCH; i++) begin
            if (in_ch && ch_idx == CI_W'(i)) begin
                case (off)
                    O_CTL:    rdata = DATA_W'(ctl_rd[i]);
                    O_IVL_LO: rdata = ivl_q[i][DATA_W-1:0];
                    O_IVL_HI: rdata = ivl_q[i][CNT_W-1:DATA_W];
                    O_CNT_LO: rdata = cnt_w[i][DATA_W-1:0];
                    O_CNT_HI: rdata = hi_snap_q;
                    default:  rdata = '0;
                endcase
            end
        end
    end

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/evt_tmr_bench.sv
module evt_tmr_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int t_mark = 0;
    int last_k = 0;
    bit done = 0;

    evt_tmr u_evt_tmr (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] a_ctl(input int n);    return 8'(8'h10 + 8'h20*n); endfunction
    function automatic logic [7:0] a_ivl_lo(input int n); return 8'(8'h14 + 8'h20*n); endfunction
    function automatic logic [7:0] a_ivl_hi(input int n); return 8'(8'h18 + 8'h20*n); endfunction
    function automatic logic [7:0] a_cnt_lo(input int n); return 8'(8'h1C + 8'h20*n); endfunction
    function automatic logic [7:0] a_cnt_hi(input int n); return 8'(8'h20 + 8'h20*n); endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 t_mark = cyc;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata; last_k = cyc - t_mark;
        @(posedge clk); @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {63'd0, irq}, 64'd0);
        rd(8'h00, v); chk("R1 ien", v, 0);
        rd(8'h04, v); chk("R1 status", v, 0);
        for (int n = 0; n < 2; n++) begin
            rd(a_ctl(n), v);    chk("R1 ctl", v, 0);
            rd(a_ivl_lo(n), v); chk("R1 ivl lo", v, 0);
            rd(a_cnt_lo(n), v); chk("R1 cnt lo", v, 0);
        end

        // R11 register map
        for (int n = 0; n < 2; n++) begin
            wr(a_ivl_lo(n), 32'hA000_0000 + n);
            wr(a_ivl_hi(n), 32'hB000_0000 + n);
        end
        for (int n = 0; n < 2; n++) begin
            rd(a_ivl_lo(n), v); chk("R11 ivl lo", v, 32'hA000_0000 + n);
            rd(a_ivl_hi(n), v); chk("R11 ivl hi", v, 32'hB000_0000 + n);
        end
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R11 unmapped", v, 0);

        // R2 control fields readback
        wr(a_ctl(1), 32'h0000_00FF);
        rd(a_ctl(1), v); chk("R2 ctl readback", v, 32'hF1);
        wr(a_ctl(1), 0); idle(3);

        // R3 R4 prescale sweep on channel 0
        wr(a_ivl_hi(0), 0);
        for (int s = 0; s < 8; s++) begin
            wr(a_ivl_lo(0), 1000);
            wr(a_ctl(0), 32'h3 | (s << 4));
            idle(3 * (1 << s) + s);
            rd(a_cnt_lo(0), v);
            chk($sformatf("R3 R4 sel %0d count", s), v, 1000 - (last_k >> s));
            rd(a_cnt_hi(0), v); chk("R3 cnt hi", v, 0);
            wr(a_ctl(0), 0); idle(3);
        end

        // R5 periodic, R7 status, R8 masking
        wr(a_ivl_lo(0), 4);
        wr(a_ctl(0), 32'h3);
        for (int j = 0; j < 6; j++) begin
            rd(a_cnt_lo(0), v);
            chk("R5 periodic count", v, 4 - (last_k % 4));
        end
        rd(8'h04, v); chk("R7 status set", v & 1, 1);
        chk("R8 irq masked", {63'd0, irq}, 0);
        wr(8'h00, 1);
        chk("R8 irq on", {63'd0, irq}, 1);
        wr(a_ctl(0), 0); idle(3);
        wr(8'h04, 0);
        rd(8'h04, v); chk("R7 write 0 keeps", v & 1, 1);
        wr(8'h04, 1);
        rd(8'h04, v); chk("R7 write 1 clears", v, 0);
        chk("R8 irq off", {63'd0, irq}, 0);

        // R6 one-shot on channel 1
        wr(a_ivl_lo(1), 3); wr(a_ivl_hi(1), 0);
        wr(a_ctl(1), 32'h83);
        idle(10);
        rd(a_cnt_lo(1), v); chk("R6 count zero", v, 0);
        rd(a_ctl(1), v);    chk("R6 enable cleared", v, 32'h80);
        rd(8'h04, v);       chk("R6 R7 status bit1", v, 2);
        chk("R8 irq bit1 masked", {63'd0, irq}, 0);
        idle(5);
        rd(a_cnt_lo(1), v); chk("R6 stays zero", v, 0);
        wr(8'h04, 2);

        // R9 disable window, R12 resume
        wr(a_ivl_lo(0), 100000);
        wr(a_ctl(0), 32'h3);
        idle(5);
        wr(a_ctl(0), 0);
        idle(1);
        rd(a_cnt_lo(0), v);
        idle(10);
        rd(a_cnt_lo(0), h); chk("R9 held after disable", h, v);
        wr(a_ctl(0), 32'h1);
        idle(5);
        rd(a_cnt_lo(0), v); chk("R12 resume", v, h - (last_k - 1));
        wr(a_ctl(0), 0); idle(3);

        // R10 coherent read across low-word wrap
        wr(a_ivl_lo(1), 2); wr(a_ivl_hi(1), 1);
        wr(a_ctl(1), 32'h3);
        idle(2);
        rd(a_cnt_lo(1), v);
        begin
            int k0;
            k0 = last_k;
            rd(a_cnt_hi(1), h);
            chk("R10 coherent", {h, v}, 64'h1_0000_0002 - 64'(k0));
        end
        chk("R10 hi", h, 1);
        wr(a_ctl(1), 0); idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule